// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block is a small copy engine that fills the 8 KiB video memory window from anywhere in a 16-bit address space, one 16-byte block at a time. Software programs a source pointer, a destination pointer and a control byte through five byte-wide registers. The control byte holds the block count and the trigger mode.

In immediate mode, writing the control byte copies every requested block back to back. In line-paced mode, the engine arms itself and copies exactly one block on each rising edge of the horizontal-blank input. It becomes inactive when the count runs out, or when software cancels it by writing the control byte again with the mode bit clear.

The engine masters a single memory port. Each byte takes two clocks: one clock reads it from the source address and the next clock writes it to the folded destination address.

Top module: `vblk_dma`

## Requirements
- R1: After reset, register selects 0 to 3 read 0x00, select 4 (control) reads 0xFF, and `busy` and `mem_we` are low.
- R2: Register select 0 and 2 are the source and destination address bits 15..8. Select 1 and 3 are bits 7..4, stored from write-data bits 7..4. On read, the low-byte registers return that nibble in bits 7..4 with bits 3..0 zero.
- R3: Each block reads 16 consecutive source addresses. The first is the source pointer with bits 3..0 forced to zero. Every byte written equals the byte read at the matching source address.
- R4: The byte with index i of a block is written to 0x8000 OR (destination bits 12..4, shifted to bits 12..4) plus i, so every write lands in 0x8000..0x9FFF.
- R5: Writing the control register (select 4) with bit 7 = 0 while idle copies (bits 6..0) + 1 blocks back to back without any strobe. While this runs, control bit 7 reads 0.
- R6: When an immediate copy completes, both pointers have advanced by 16 times the block count, and control reads 0xFF.
- R7: Writing control with bit 7 = 1 arms line-paced mode with (bits 6..0) + 1 blocks, and no memory write happens until a strobe arrives. Each `hblank` rising edge then copies one block, advances both pointers by 16 and lowers the count. Control reads bit 7 = 0 and bits 6..0 = blocks left − 1.
- R8: After the last paced block, control reads 0xFF and further strobes cause no memory write.
- R9: A strobe held high for many cycles copies exactly one block.
- R10: A control write with bit 7 = 0 while line-paced mode is armed cancels the transfer. It starts no copy, stops memory writes from the next cycle (even in the middle of a block), and leaves the pointers unadvanced. Control then reads 0x80 OR the written bits 6..0.
- R11: While a block is moving, or an immediate copy is pending, register writes other than a cancel are ignored.
- R12: One block keeps `busy` high for exactly 32 cycles: a read cycle with `mem_we` low, then a write cycle with `mem_we` high, for each byte. `mem_we` is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 src high, 1 src low, 2 dst high, 3 dst low, 4 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| hblank | input | 1 | Horizontal-blank level; rising edge paces line mode |
| mem_addr | output | 16 | Memory address (source on read cycles, destination on write cycles) |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | High while a block is moving |

## Verification
The bench aims at the destination fold at the top of the window: a destination of 0xFFF0 must land at 0x9FF0 and wrap the pointer to zero. A design that added 0x8000 instead of folding would write outside video memory. It holds the strobe high across a whole block and beyond; a level-triggered design would copy a second block. It cancels a paced transfer both while idle and halfway through a block. A design that treated the cancel as a new immediate copy, or let the block finish, would produce extra writes. It also writes a pointer during a block, and it checks the status byte at reset, in flight and after completion, which catches an off-by-one in the count-minus-one encoding.

// File: rtl/vblk_dma_pkg.sv
package vblk_dma_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BLK_SHIFT = 4;                    // 16-byte blocks
    localparam int PTR_W     = ADDR_W - BLK_SHIFT;   // block-granular pointer
    localparam int HI_LSB    = DATA_W - BLK_SHIFT;   // pointer bit holding addr bit 8
    localparam int CNT_W     = 8;                    // holds 1..128
    localparam int LEN_W     = 7;
    localparam int BLK_CYCLES = 2 << BLK_SHIFT;      // read + write per byte

    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] WIN_MASK = 16'h1FFF;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic                 busy;
        logic                 wr_phase;
        logic [BLK_SHIFT-1:0] idx;
        logic [DATA_W-1:0]    hold;
    } mover_st_t;

    typedef struct packed {
        logic [PTR_W-1:0] src;
        logic [PTR_W-1:0] dst;
        logic [CNT_W-1:0] count;
        logic             paced;
        logic             gen_run;
    } regs_st_t;

    function automatic logic [ADDR_W-1:0] fold_dst(input logic [PTR_W-1:0] dptr,
                                                   input logic [BLK_SHIFT-1:0] idx);
        logic [ADDR_W-1:0] a;
        a = {dptr, idx};
        return (a & WIN_MASK) | WIN_BASE;
    endfunction

endpackage

// File: rtl/vblk_dma_edge.sv
module vblk_dma_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/vblk_dma_mover.sv
module vblk_dma_mover
    import vblk_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [PTR_W-1:0]  src_ptr,
    input  logic [PTR_W-1:0]  dst_ptr,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              busy,
    output logic              done
);
    localparam logic [BLK_SHIFT-1:0] LAST = '1;

    mover_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (abort) begin
            st_d.busy     = 1'b0;
            st_d.wr_phase = 1'b0;
            st_d.idx      = '0;
        end else if (st_q.busy) begin
            if (!st_q.wr_phase) begin
                st_d.hold     = rdata;
                st_d.wr_phase = 1'b1;
            end else begin
                st_d.wr_phase = 1'b0;
                st_d.idx      = st_q.idx + 1'b1;
                if (st_q.idx == LAST) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end
            end
        end else if (start) begin
            st_d.busy     = 1'b1;
            st_d.wr_phase = 1'b0;
            st_d.idx      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign we    = st_q.busy & st_q.wr_phase;
    assign wdata = st_q.hold;
    assign addr  = we ? fold_dst(dst_ptr, st_q.idx) : {src_ptr, st_q.idx};
endmodule

// File: rtl/vblk_dma_regs.sv
module vblk_dma_regs
    import vblk_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              hb_rise,
    input  logic              mv_busy,
    input  logic              blk_done,
    output logic [PTR_W-1:0]  src_ptr,
    output logic [PTR_W-1:0]  dst_ptr,
    output logic              start,
    output logic              abort,
    output logic              paced_on
);
    regs_st_t r_q, r_d;
    logic ctl_wr, locked, running;
    logic [LEN_W-1:0] left_m1;

    assign ctl_wr = we && (sel == SEL_CTRL);
    assign abort  = ctl_wr && !wdata[DATA_W-1] && r_q.paced;
    assign start  = !mv_busy && !abort && (r_q.gen_run || (r_q.paced && hb_rise));
    assign locked = mv_busy | r_q.gen_run | start;

    always_comb begin
        r_d = r_q;
        if (abort) begin
            r_d.paced = 1'b0;
            r_d.count = CNT_W'(wdata[LEN_W-1:0]) + CNT_W'(1);
        end else if (blk_done) begin
            r_d.src   = r_q.src + 1'b1;
            r_d.dst   = r_q.dst + 1'b1;
            r_d.count = r_q.count - 1'b1;
            if (r_q.count == CNT_W'(1)) begin
                r_d.paced   = 1'b0;
                r_d.gen_run = 1'b0;
            end
        end else if (we && !locked) begin
            case (reg_sel_e'(sel))
                SEL_SRC_HI: r_d.src[PTR_W-1:HI_LSB] = wdata;
                SEL_SRC_LO: r_d.src[HI_LSB-1:0]     = wdata[DATA_W-1:HI_LSB];
                SEL_DST_HI: r_d.dst[PTR_W-1:HI_LSB] = wdata;
                SEL_DST_LO: r_d.dst[HI_LSB-1:0]     = wdata[DATA_W-1:HI_LSB];
                SEL_CTRL: begin
                    r_d.count   = CNT_W'(wdata[LEN_W-1:0]) + CNT_W'(1);
                    r_d.paced   = wdata[DATA_W-1];
                    r_d.gen_run = !wdata[DATA_W-1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign running = r_q.paced | r_q.gen_run | mv_busy;
    assign left_m1 = LEN_W'(r_q.count - CNT_W'(1));

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_SRC_HI: rdata = r_q.src[PTR_W-1:HI_LSB];
            SEL_SRC_LO: rdata = {r_q.src[HI_LSB-1:0], {BLK_SHIFT{1'b0}}};
            SEL_DST_HI: rdata = r_q.dst[PTR_W-1:HI_LSB];
            SEL_DST_LO: rdata = {r_q.dst[HI_LSB-1:0], {BLK_SHIFT{1'b0}}};
            SEL_CTRL:   rdata = {~running, left_m1};
            default:    rdata = '1;
        endcase
    end

    assign src_ptr  = r_q.src;
    assign dst_ptr  = r_q.dst;
    assign paced_on = r_q.paced;
endmodule

// File: rtl/vblk_dma.sv
module vblk_dma
    import vblk_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hblank,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy
);
    logic             hb_rise, start, abort_req, blk_done, paced_on;
    logic [PTR_W-1:0] src_ptr, dst_ptr;

    vblk_dma_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (hblank),
        .rise  (hb_rise)
    );

    vblk_dma_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .hb_rise  (hb_rise),
        .mv_busy  (busy),
        .blk_done (blk_done),
        .src_ptr  (src_ptr),
        .dst_ptr  (dst_ptr),
        .start    (start),
        .abort    (abort_req),
        .paced_on (paced_on)
    );

    vblk_dma_mover u_mover (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort_req),
        .src_ptr (src_ptr),
        .dst_ptr (dst_ptr),
        .rdata   (mem_rdata),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .we      (mem_we),
        .busy    (busy),
        .done    (blk_done)
    );
endmodule

// File: rtl/vblk_dma_chk.sv
module vblk_dma_chk
    import vblk_dma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              ctl_mode_bit,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              busy,
    input logic              paced_on,
    input logic              abort_req
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1'b1;
    end

    assert_we_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_addr & ~WIN_MASK) == WIN_BASE));

    assert_we_needs_busy_R12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    assert_byte_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == $past(mem_rdata)) && !$past(mem_we));

    assert_block_start_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_addr[BLK_SHIFT-1:0] == '0));

    assert_cancel_halts_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_CTRL && !ctl_mode_bit && paced_on) |=> (!busy && !mem_we));

    assert_block_length_R12: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(abort_req)) |-> (run_len == 8'(BLK_CYCLES)));
endmodule

bind vblk_dma vblk_dma_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .ctl_mode_bit (reg_wdata[7]),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .busy         (busy),
    .paced_on     (paced_on),
    .abort_req    (abort_req)
);

// File: tb/vblk_dma_bench.sv
module vblk_dma_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        hblank = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int busy_cycles = 0;
    bit loose = 1'b0;
    logic [23:0] exp_q[$];
    logic [23:0] e;

    always #4 clk = ~clk;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = src_byte(mem_addr);

    vblk_dma u_vblk_dma (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hblank    (hblank),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .busy      (busy)
    );

    // monitor: pops expected writes and compares
    always @(negedge clk) begin
        if (busy) busy_cycles++;
        if (mem_we) begin
            wr_count++;
            if (!loose) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 R8 R10 unexpected write: got addr=%h data=%h expected none",
                             mem_addr, mem_wdata);
                end else begin
                    e = exp_q.pop_front();
                    if ({mem_addr, mem_wdata} !== e) begin
                        errors++;
                        $display("FAIL R3 R4 write: got %h expected %h", {mem_addr, mem_wdata}, e);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_sel = sel;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic push_block(input logic [15:0] src, input logic [15:0] dst);
        for (int i = 0; i < 16; i++)
            exp_q.push_back({3'b100, dst[12:4], 4'(i), src_byte({src[15:4], 4'(i)})});
    endtask

    task automatic hb(input int n);
        @(posedge clk); #1 hblank = 1'b1;
        repeat (n) @(posedge clk);
        #1 hblank = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(posedge clk); #1;
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_chk(3'd0, 8'h00, "R1 src hi");
        rd_chk(3'd1, 8'h00, "R1 src lo");
        rd_chk(3'd2, 8'h00, "R1 dst hi");
        rd_chk(3'd3, 8'h00, "R1 dst lo");
        rd_chk(3'd4, 8'hFF, "R1 control");
        chk("R1 busy", busy, 0);
        chk("R1 mem_we", mem_we, 0);

        // R2 pointer readback
        wr(3'd0, 8'h12); wr(3'd1, 8'h3F);
        wr(3'd2, 8'h55); wr(3'd3, 8'h67);
        rd_chk(3'd0, 8'h12, "R2 src hi");
        rd_chk(3'd1, 8'h30, "R2 src lo");
        rd_chk(3'd2, 8'h55, "R2 dst hi");
        rd_chk(3'd3, 8'h60, "R2 dst lo");

        // R5 immediate copy of two blocks, R11 write ignored
        push_block(16'h1230, 16'h5560);
        push_block(16'h1240, 16'h5570);
        wr(3'd4, 8'h01);
        rd_chk(3'd4, 8'h01, "R5 status while running");
        wr(3'd0, 8'hAA);
        wait_idle();
        chk("R5 all blocks written", exp_q.size(), 0);
        rd_chk(3'd0, 8'h12, "R11 src hi unchanged by write during copy");
        rd_chk(3'd1, 8'h50, "R6 src lo advanced");
        rd_chk(3'd2, 8'h55, "R6 dst hi");
        rd_chk(3'd3, 8'h80, "R6 dst lo advanced");
        rd_chk(3'd4, 8'hFF, "R6 control after completion");

        // R4 window fold at top, R12 block length
        wr(3'd0, 8'h01); wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hF0);
        push_block(16'h0100, 16'hFFF0);
        busy_cycles = 0;
        wr(3'd4, 8'h00);
        wait_idle();
        chk("R4 folded block written", exp_q.size(), 0);
        chk("R12 busy cycles per block", busy_cycles, 32);
        rd_chk(3'd2, 8'h00, "R4 dst hi wraps");
        rd_chk(3'd3, 8'h00, "R4 dst lo wraps");
        rd_chk(3'd1, 8'h10, "R6 src lo one block");

        // R7 paced mode, three blocks
        wr(3'd0, 8'h20); wr(3'd1, 8'h00);
        wr(3'd2, 8'h80); wr(3'd3, 8'h00);
        wr(3'd4, 8'h82);
        rd_chk(3'd4, 8'h02, "R7 armed status");
        n = wr_count;
        repeat (30) @(posedge clk);
        chk("R7 no write before strobe", wr_count - n, 0);
        push_block(16'h2000, 16'h8000);
        n = wr_count;
        @(posedge clk); #1 hblank = 1'b1;
        wr(3'd0, 8'h77);
        wait_idle();
        repeat (40) @(posedge clk);
        #1 hblank = 1'b0;
        chk("R7 first block written", exp_q.size(), 0);
        chk("R9 held strobe copies one block", wr_count - n, 16);
        rd_chk(3'd4, 8'h01, "R7 status after block 1");
        rd_chk(3'd0, 8'h20, "R11 src hi unchanged by write during block");
        rd_chk(3'd1, 8'h10, "R7 src lo advanced");
        rd_chk(3'd3, 8'h10, "R7 dst lo advanced");
        push_block(16'h2010, 16'h8010);
        hb(1); wait_idle();
        rd_chk(3'd4, 8'h00, "R7 status after block 2");
        push_block(16'h2020, 16'h8020);
        hb(1); wait_idle();
        chk("R7 third block written", exp_q.size(), 0);
        rd_chk(3'd4, 8'hFF, "R8 inactive after last block");
        n = wr_count;
        hb(1); repeat (40) @(posedge clk);
        chk("R8 strobe after completion ignored", wr_count - n, 0);
        rd_chk(3'd1, 8'h30, "R8 src lo final");

        // R10 cancel while armed and idle
        wr(3'd4, 8'h85);
        rd_chk(3'd4, 8'h05, "R7 armed six blocks");
        n = wr_count;
        wr(3'd4, 8'h03);
        rd_chk(3'd4, 8'h83, "R10 status after cancel");
        hb(1); repeat (40) @(posedge clk);
        chk("R10 no copy after cancel", wr_count - n, 0);
        rd_chk(3'd1, 8'h30, "R10 src lo not advanced");

        // R10 cancel in the middle of a block
        loose = 1'b1;
        wr(3'd4, 8'h81);
        hb(1);
        repeat (8) @(posedge clk);
        wr(3'd4, 8'h05);
        n = wr_count;
        chk("R10 busy dropped by cancel", busy, 0);
        repeat (40) @(posedge clk);
        chk("R10 no write after mid-block cancel", wr_count - n, 0);
        rd_chk(3'd4, 8'h85, "R10 status after mid-block cancel");
        rd_chk(3'd1, 8'h30, "R10 src lo not advanced mid-block");
        loose = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule